// File: doc/BRIEF.md
# Display Start Address Scroll Latch

This block is the scrolling front end of a CRT display controller. The processor programs a set of byte-wide registers through an index/data write port. The registers are a 16-bit display start address, a row offset, a fine horizontal pixel shift, a control bit that picks whether the first fetch of each line is even or odd, a preset starting row scan line and a maximum row scan line. An external timing generator supplies a vertical sync level and three one-cycle strobes: top of frame, end of horizontal retrace and start of active display.

The programmed start address is copied into a working frame-start register only on the rising edge of vertical sync. Both bytes are taken in the same clock, so software can rewrite the address at any point in a frame without tearing the frame that is on screen. At the top of the frame, the line start address reloads from that latched copy. At each horizontal retrace end, the row scan counter steps. When a character row is complete, the line start address moves forward by the row offset.

With each line start, the block also produces the address of the first fetch, whose low bit is set by the odd/even control. The pixel shift is not latched per frame. It is sampled at the start of every active display period, so it can change from line to line. Software scrolls smoothly by stepping the start address one byte at a time and alternating the pixel shift within each byte.

Top module: `scroll_latch_top`

## Requirements
- R1: A synchronous active-high reset clears all registers. In the cycle after reset, line_addr, fetch_addr, row_scan and pan_out are all 0.
- R2: A write (wr_en high) to a register index has the following effect:
  - Index 0 sets start address bits 15:8.
  - Index 1 sets start address bits 7:0.
  - Index 2 sets the row offset in words.
  - Index 3 sets the pixel shift from wr_data bits 3:0.
  - Index 4 sets the odd/even control from bit 0.
  - Index 5 sets the preset row from bits 4:0.
  - Index 6 sets the maximum row from bits 4:0.
  
  Writes to indices 7 to 15 have no effect on any output.
- R3: The frame-start register takes the full 16-bit programmed start address only in the clock after vsync is sampled high following a low sample. Start address writes made between two such edges do not reach line_addr at a frame top until the next rising edge.
- R4: On a frame_top strobe, line_addr loads the frame-start register and row_scan loads the preset row. With a preset of 0, the first line uses row 0.
- R5: On a line_end strobe without frame_top, the block acts on row_scan as follows:
  - If row_scan equals the maximum row, row_scan becomes 0 and line_addr increases by twice the row offset, modulo 2^16.
  - Otherwise row_scan increases by 1, wrapping modulo 32, and line_addr holds.
  
  frame_top takes precedence over line_end.
- R6: Each time line_addr updates, fetch_addr updates with it. fetch_addr bits 15:1 equal the new line_addr bits 15:1, and bit 0 equals the odd/even control bit in that cycle (0 gives even, 1 gives odd).
- R7: On a disp_start strobe, pan_out loads the current pixel shift register. Between strobes it holds, so a new shift value shows from the next active display start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_index | input | 4 | Register index for the write |
| wr_data | input | 8 | Register write data |
| vsync | input | 1 | Vertical sync level from the timing generator |
| frame_top | input | 1 | One-cycle strobe at the first line of a frame |
| line_end | input | 1 | One-cycle strobe at the end of horizontal retrace |
| disp_start | input | 1 | One-cycle strobe at the start of active display of a line |
| line_addr | output | 16 | Start address of the current scanline |
| fetch_addr | output | 16 | First fetch address of the line, with the low bit set by the odd/even control |
| row_scan | output | 5 | Current character row scan line |
| pan_out | output | 4 | Pixel shift passed to the serializer |

## Verification
The assertions take for granted that the timing strobes are single-cycle pulses sampled on the character clock. They also assume that a register write in the same cycle as a latch point acts after that latch point. The assertions therefore compare each loaded value against the previous cycle's register contents. The random stimulus drives strobes, vsync transitions and writes to all sixteen indices independently, including same-cycle collisions. The bench model applies the same rule as the design: old register value at the edge, new value after it. Directed sequences rewrite the start address while vsync stays high, and cover an odd start with even fetches, a zero preset row, and a one-byte stepping pan.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int PAN_W  = 4;
  localparam int ROW_W  = 5;
  localparam int IDX_W  = 4;

  typedef enum logic [IDX_W-1:0] {
    IX_START_HI = 4'd0,
    IX_START_LO = 4'd1,
    IX_OFFSET   = 4'd2,
    IX_PAN      = 4'd3,
    IX_CTRL     = 4'd4,
    IX_PRESET   = 4'd5,
    IX_MAXROW   = 4'd6
  } idx_e;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [DATA_W-1:0] offset;
    logic [PAN_W-1:0]  pan;
    logic              som;
    logic [ROW_W-1:0]  preset;
    logic [ROW_W-1:0]  max_row;
  } regs_t;

  // Advance a line start by one character row (offset counted in words).
  function automatic logic [ADDR_W-1:0] advance_row(input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] offset);
    logic [ADDR_W-1:0] step;
    step = ADDR_W'({offset, 1'b0});
    return addr + step;
  endfunction

  // First fetch of a line: low bit chosen by the odd/even control.
  function automatic logic [ADDR_W-1:0] first_fetch(input logic [ADDR_W-1:0] addr,
                                                    input logic som);
    return {addr[ADDR_W-1:1], som};
  endfunction
endpackage

// File: rtl/scroll_regs.sv
module scroll_regs
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [DATA_W-1:0] wr_data,
  output regs_t             regs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_en) begin
      case (idx_e'(wr_index))
        IX_START_HI: regs.start[ADDR_W-1:DATA_W] <= wr_data;
        IX_START_LO: regs.start[DATA_W-1:0]      <= wr_data;
        IX_OFFSET:   regs.offset                 <= wr_data;
        IX_PAN:      regs.pan                    <= wr_data[PAN_W-1:0];
        IX_CTRL:     regs.som                    <= wr_data[0];
        IX_PRESET:   regs.preset                 <= wr_data[ROW_W-1:0];
        IX_MAXROW:   regs.max_row                <= wr_data[ROW_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scroll_frame_latch.sv
module scroll_frame_latch
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync,
  input  logic [ADDR_W-1:0] start_reg,
  output logic              vs_rise,
  output logic [ADDR_W-1:0] frame_start
);
  logic vsync_q;

  assign vs_rise = vsync && !vsync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_q     <= 1'b0;
      frame_start <= '0;
    end else begin
      vsync_q <= vsync;
      if (vs_rise) frame_start <= start_reg;
    end
  end
endmodule

// File: rtl/scroll_line_counter.sv
module scroll_line_counter
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_top,
  input  logic              line_end,
  input  logic [ADDR_W-1:0] frame_start,
  input  regs_t             regs,
  output logic              row_wrap,
  output logic [ADDR_W-1:0] line_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ROW_W-1:0]  row_scan
);
  logic [ADDR_W-1:0] nxt_line;
  logic [ROW_W-1:0]  nxt_row;
  logic              line_event;

  assign line_event = frame_top || line_end;
  assign row_wrap   = line_end && !frame_top && (row_scan == regs.max_row);

  always_comb begin
    nxt_line = line_addr;
    nxt_row  = row_scan;
    if (frame_top) begin
      nxt_line = frame_start;
      nxt_row  = regs.preset;
    end else if (row_wrap) begin
      nxt_line = advance_row(line_addr, regs.offset);
      nxt_row  = '0;
    end else if (line_end) begin
      nxt_row  = row_scan + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_addr  <= '0;
      fetch_addr <= '0;
      row_scan   <= '0;
    end else if (line_event) begin
      line_addr  <= nxt_line;
      row_scan   <= nxt_row;
      fetch_addr <= first_fetch(nxt_line, regs.som);
    end
  end
endmodule

// File: rtl/scroll_pan.sv
module scroll_pan
  import scroll_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_start,
  input  logic [PAN_W-1:0] pan_reg,
  output logic [PAN_W-1:0] pan_out
);
  always_ff @(posedge clk) begin
    if (rst)             pan_out <= '0;
    else if (disp_start) pan_out <= pan_reg;
  end
endmodule

// File: rtl/scroll_latch_top.sv
module scroll_latch_top
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vsync,
  input  logic              frame_top,
  input  logic              line_end,
  input  logic              disp_start,
  output logic [ADDR_W-1:0] line_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ROW_W-1:0]  row_scan,
  output logic [PAN_W-1:0]  pan_out
);
  regs_t             regs;
  logic              vs_rise;
  logic              row_wrap;
  logic [ADDR_W-1:0] frame_start;

  scroll_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_index(wr_index),
    .wr_data(wr_data), .regs(regs)
  );

  scroll_frame_latch u_latch (
    .clk(clk), .rst(rst), .vsync(vsync), .start_reg(regs.start),
    .vs_rise(vs_rise), .frame_start(frame_start)
  );

  scroll_line_counter u_line (
    .clk(clk), .rst(rst), .frame_top(frame_top), .line_end(line_end),
    .frame_start(frame_start), .regs(regs), .row_wrap(row_wrap),
    .line_addr(line_addr), .fetch_addr(fetch_addr), .row_scan(row_scan)
  );

  scroll_pan u_pan (
    .clk(clk), .rst(rst), .disp_start(disp_start), .pan_reg(regs.pan),
    .pan_out(pan_out)
  );
endmodule

// File: rtl/scroll_latch_chk.sv
module scroll_latch_chk
  import scroll_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_index,
  input logic              frame_top,
  input logic              line_end,
  input logic              disp_start,
  input logic [ADDR_W-1:0] line_addr,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ROW_W-1:0]  row_scan,
  input logic [PAN_W-1:0]  pan_out,
  input regs_t             regs,
  input logic              vs_rise,
  input logic              row_wrap,
  input logic [ADDR_W-1:0] frame_start
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (line_addr == '0 && fetch_addr == '0 && row_scan == '0 && pan_out == '0));

  assert_ignored_index_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_index > 4'd6) |=> $stable(regs));

  assert_latch_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    vs_rise |=> frame_start == $past(regs.start));

  assert_hold_between_edges_R3: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(frame_start));

  assert_frame_reload_R4: assert property (@(posedge clk) disable iff (rst)
    frame_top |=> (line_addr == $past(frame_start) && row_scan == $past(regs.preset)));

  assert_row_step_R5: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_top && !row_wrap) |=> ($stable(line_addr) && row_scan == $past(row_scan) + 5'd1));

  assert_row_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    row_wrap |=> (row_scan == '0 &&
                  line_addr == $past(line_addr) + ADDR_W'({$past(regs.offset), 1'b0})));

  assert_fetch_parity_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_top || line_end) |=> (fetch_addr[0] == $past(regs.som) &&
                                 fetch_addr[ADDR_W-1:1] == line_addr[ADDR_W-1:1]));

  assert_pan_load_R7: assert property (@(posedge clk) disable iff (rst)
    disp_start |=> pan_out == $past(regs.pan));

  assert_pan_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !disp_start |=> $stable(pan_out));
endmodule

bind scroll_latch_top scroll_latch_chk u_chk (.*);

// File: tb/scroll_latch_top_test.sv
module scroll_latch_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_index = '0;
  logic [7:0]  wr_data = '0;
  logic        vsync = 1'b0;
  logic        frame_top = 1'b0;
  logic        line_end = 1'b0;
  logic        disp_start = 1'b0;
  logic [15:0] line_addr, fetch_addr;
  logic [4:0]  row_scan;
  logic [3:0]  pan_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side expectations
  logic [15:0] m_start, m_fs, m_line, m_fetch;
  logic [7:0]  m_off;
  logic [3:0]  m_pan, m_panout;
  logic        m_som, m_vq;
  logic [4:0]  m_pre, m_max, m_row;

  always #5 clk = ~clk;

  scroll_latch_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_index(wr_index), .wr_data(wr_data),
    .vsync(vsync), .frame_top(frame_top), .line_end(line_end), .disp_start(disp_start),
    .line_addr(line_addr), .fetch_addr(fetch_addr), .row_scan(row_scan), .pan_out(pan_out)
  );

  function automatic logic [15:0] exp_advance(logic [15:0] a, logic [7:0] words);
    return a + 16'(words) * 16'd2;
  endfunction

  function automatic logic [15:0] exp_fetch(logic [15:0] a, logic odd);
    return (a & 16'hFFFE) | 16'(odd);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [15:0] n_line;
    if (rst) begin
      {m_start, m_fs, m_line, m_fetch, m_off, m_pan, m_panout} = '0;
      {m_som, m_vq, m_pre, m_max, m_row} = '0;
      return;
    end
    if (frame_top) begin
      m_line  = m_fs;
      m_row   = m_pre;
      m_fetch = exp_fetch(m_fs, m_som);
    end else if (line_end) begin
      if (m_row == m_max) begin
        m_line = exp_advance(m_line, m_off);
        m_row  = 5'd0;
      end else begin
        m_row = m_row + 5'd1;
      end
      n_line  = m_line;
      m_fetch = exp_fetch(n_line, m_som);
    end
    if (disp_start) m_panout = m_pan;
    if (vsync && !m_vq) m_fs = m_start;
    m_vq = vsync;
    if (wr_en) begin
      case (wr_index)
        4'd0: m_start[15:8] = wr_data;
        4'd1: m_start[7:0]  = wr_data;
        4'd2: m_off = wr_data;
        4'd3: m_pan = wr_data[3:0];
        4'd4: m_som = wr_data[0];
        4'd5: m_pre = wr_data[4:0];
        4'd6: m_max = wr_data[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    check("R4/R5 line_addr", 32'(line_addr), 32'(m_line));
    check("R6 fetch_addr", 32'(fetch_addr), 32'(m_fetch));
    check("R4/R5 row_scan", 32'(row_scan), 32'(m_row));
    check("R7 pan_out", 32'(pan_out), 32'(m_panout));
  endtask

  // one clock: design and bench expectation advance together, then compare
  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
    wr_en = 1'b0; frame_top = 1'b0; line_end = 1'b0; disp_start = 1'b0;
  endtask

  task automatic wr(logic [3:0] idx, logic [7:0] d);
    wr_en = 1'b1; wr_index = idx; wr_data = d;
    tick();
  endtask

  task automatic vs_pulse();
    vsync = 1'b1; tick();
    vsync = 1'b0; tick();
  endtask

  task automatic top_of_frame();
    frame_top = 1'b1; tick();
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 line_addr", 32'(line_addr), 0);
    check("R1 fetch_addr", 32'(fetch_addr), 0);
    check("R1 row_scan", 32'(row_scan), 0);
    check("R1 pan_out", 32'(pan_out), 0);

    // R3/R4: odd start, even fetch, preset 0
    wr(4'd0, 8'h12); wr(4'd1, 8'h35); wr(4'd5, 8'h00); wr(4'd4, 8'h00);
    vs_pulse(); top_of_frame();
    check("R3 latched start", 32'(line_addr), 32'h1235);
    check("R6 even first fetch", 32'(fetch_addr), 32'h1234);
    check("R4 preset zero row", 32'(row_scan), 0);

    // R3: rewrite with vsync held high, no edge
    vsync = 1'b1; tick();
    wr(4'd0, 8'h56); wr(4'd1, 8'h78);
    top_of_frame();
    check("R3 no edge keeps old", 32'(line_addr), 32'h1235);
    vsync = 1'b0; tick(); vsync = 1'b1; tick();
    top_of_frame();
    check("R3 new edge takes new", 32'(line_addr), 32'h5678);
    vsync = 1'b0; tick();

    // R6 odd control
    wr(4'd4, 8'h01); wr(4'd1, 8'h10); vs_pulse(); top_of_frame();
    check("R6 odd first fetch", 32'(fetch_addr), 32'h5611);

    // R5: max row 1, offset 40 words
    wr(4'd6, 8'h01); wr(4'd2, 8'd40);
    top_of_frame();
    line_end = 1'b1; tick();
    check("R5 step row", 32'(row_scan), 1);
    check("R5 hold addr", 32'(line_addr), 32'h5610);
    line_end = 1'b1; tick();
    check("R5 wrap row", 32'(row_scan), 0);
    check("R5 advance", 32'(line_addr), 32'h5610 + 80);

    // R2 ignored index, R7 per-line pan
    wr(4'd9, 8'hFF); wr(4'd15, 8'hAB);
    disp_start = 1'b1; tick();
    check("R2 ignored index pan", 32'(pan_out), 0);
    wr(4'd3, 8'hF4);
    check("R7 no strobe hold", 32'(pan_out), 0);
    disp_start = 1'b1; tick();
    check("R7 next line pan", 32'(pan_out), 4);

    // R7/R3 stepping pan: (0,4) (1,0) (1,4) (2,0) monotonic position
    begin
      int last_pos = -1;
      for (int s = 0; s < 8; s++) begin
        wr(4'd0, 8'h00); wr(4'd1, 8'((s + 1) / 2)); wr(4'd3, (s % 2 == 0) ? 8'd4 : 8'd0);
        vs_pulse(); top_of_frame();
        disp_start = 1'b1; tick();
        check("R7 smooth pan position rises",
              32'((int'(line_addr) * 8 + int'(pan_out)) > last_pos), 1);
        last_pos = int'(line_addr) * 8 + int'(pan_out);
      end
    end

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 20) begin wr_en = 1'b1; wr_index = 4'($urandom_range(0, 15)); wr_data = 8'($urandom); end
      if ($urandom_range(0, 9) == 0) vsync = ~vsync;
      frame_top  = ($urandom_range(0, 29) == 0);
      line_end   = ($urandom_range(0, 3) == 0);
      disp_start = ($urandom_range(0, 3) == 0);
      tick();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240215));
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule